// File: doc/BRIEF.md
# Edge-triggered reset control bank

This block keeps a small bank of word-addressed reset control registers for a group of peripherals, a DMA engine with several channels, and a set of processor cores. Software writes reset-request bits through a simple 32-bit write/read port. On every write, the block compares each reset bit's stored value with the value being written. A reset action is issued only when the two differ. The new value is then stored in every case.

An action depends on the kind of target. A peripheral bit that changes in either direction gives a one-cycle cold-reset pulse to that peripheral. The single DMA bit fans out, so one change pulses every DMA channel output in the same cycle. A core bit has a different action for each direction. Going from 0 to 1 raises a power-off request. Going from 1 to 0 raises a power-on-and-reset request. Either request stays high until the core's power controller acknowledges it.

A few further registers (timer, power domain, debug, reset mode) are plain storage with fixed reset values and reserved bits. They drive no output from this block.

Top module: `rst_edge_bank`

## Requirements
- R1: After reset, the registers read as follows:
  - index 0 (core): 0x17
  - index 1 (DMA): 0x1
  - index 2 (timer): 0xF
  - index 3 (power domain): 0x3
  - index 4 (debug): 0x33
  - index 5 (mode): 0x1
  - indices 6 to 6+N_PERIPH-1 (one per peripheral, peripheral i at index 6+i): 0x1

  No reset pulse and no core request is active after reset.
- R2: The writable bit masks are:
  - core: 0x17
  - DMA: 0x1
  - timer: 0xF
  - power domain: 0x3
  - debug: 0x33
  - mode: 0x07
  - each peripheral: 0x1

  Bits outside a register's mask read as zero and ignore writes. An index with no register reads as zero, and writes to it change nothing.
- R3: A write to a register stores the masked written value, whether or not any reset bit changed. rdata_o shows the register selected by addr_i combinationally.
- R4: When a write changes bit 0 of peripheral register i, periph_rst_o[i] is high for exactly the cycle after that write. This holds for changes in either direction. Rewriting the same value gives no pulse.
- R5: When a write changes bit 0 of the DMA register, all dma_rst_o bits are high together for the cycle after that write. No other pattern of dma_rst_o occurs.
- R6: Core register bit c belongs to core c. When a write changes that bit from 0 to 1, core_off_req_o[c] rises in the cycle after the write. When a write changes it from 1 to 0, core_on_req_o[c] rises in the cycle after the write. Either request stays high until core_ack_i[c] is sampled high.
- R7: For each core, at most one request is active at a time. A new edge on a core bit replaces any pending request, and it takes priority over an acknowledge in the same cycle. An acknowledge with no new edge clears the request.
- R8: A peripheral whose bit in PERIPH_TGT is 0 has no target. A change of its bit is stored but never produces a pulse on periph_rst_o.
- R9: Writes to the timer, power-domain, debug and mode registers, and writes to the core register's non-core bits (bits 2 and 4), produce no pulse and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W | Register word index for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of register at addr_i |
| periph_rst_o | output | N_PERIPH | One-cycle cold-reset pulse per peripheral |
| dma_rst_o | output | N_DMA | One-cycle reset pulse per DMA channel |
| core_off_req_o | output | N_CORE | Power-off request per core, held until acknowledged |
| core_on_req_o | output | N_CORE | Power-on-and-reset request per core, held until acknowledged |
| core_ack_i | input | N_CORE | Acknowledge from the core power controller |

## Verification
Directed sequences first rewrite unchanged values. These runs tell edge triggering apart from level triggering, because a level-based design would pulse on them. Next, each direction of change is applied to a peripheral, to the DMA bit and to the core bits. This separates the two core request kinds, and it shows that a peripheral pulses on both the rise and the fall. Reserved-bit and unmapped-index writes of all ones show that masking and decoding are correct. A write to the peripheral without a target shows that its change is stored but gives no output. Random writes, with random acknowledges and invalid indices mixed in, then exercise request replacement and acknowledge collisions against a bench model.

// File: rtl/rst_edge_pkg.sv
package rst_edge_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned IDX_CORE    = 0;
  localparam int unsigned IDX_DMA     = 1;
  localparam int unsigned IDX_TIMER   = 2;
  localparam int unsigned IDX_PWRDOM  = 3;
  localparam int unsigned IDX_DEBUG   = 4;
  localparam int unsigned IDX_MODE    = 5;
  localparam int unsigned IDX_PERIPH0 = 6;

  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_OFF  = 2'd1,
    REQ_ON   = 2'd2
  } core_req_e;

  function automatic logic [DATA_W-1:0] reg_mask(int unsigned idx, int unsigned n_regs);
    if (idx >= n_regs) return '0;
    case (idx)
      IDX_CORE:   return 32'h17;
      IDX_DMA:    return 32'h1;
      IDX_TIMER:  return 32'hF;
      IDX_PWRDOM: return 32'h3;
      IDX_DEBUG:  return 32'h33;
      IDX_MODE:   return 32'h07;
      default:    return 32'h1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_init(int unsigned idx, int unsigned n_regs);
    if (idx >= n_regs) return '0;
    case (idx)
      IDX_CORE:   return 32'h17;
      IDX_DMA:    return 32'h1;
      IDX_TIMER:  return 32'hF;
      IDX_PWRDOM: return 32'h3;
      IDX_DEBUG:  return 32'h33;
      IDX_MODE:   return 32'h1;
      default:    return 32'h1;
    endcase
  endfunction
endpackage

// File: rtl/rst_edge_regs.sv
module rst_edge_regs
  import rst_edge_pkg::*;
#(
  parameter int unsigned N_PERIPH = 6,
  parameter int unsigned N_CORE   = 2,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [N_CORE-1:0]   core_rise_o,
  output logic [N_CORE-1:0]   core_fall_o,
  output logic                dma_chg_o,
  output logic [N_PERIPH-1:0] periph_chg_o
);
  localparam int unsigned N_REGS = IDX_PERIPH0 + N_PERIPH;

  logic [N_REGS-1:0]             hit;
  logic [N_REGS-1:0][DATA_W-1:0] rd_part;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = reg_mask(r, N_REGS);
    localparam logic [DATA_W-1:0] INIT = reg_init(r, N_REGS);
    logic [DATA_W-1:0] q;

    assign hit[r] = we_i && (addr_i == ADDR_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= INIT;
      else if (hit[r]) q <= wdata_i & MASK;
    end

    assign rd_part[r] = (addr_i == ADDR_W'(r)) ? q : '0;

    // edge detect against the stored value, before the write lands
    if (r == IDX_CORE) begin : g_core
      assign core_rise_o = {N_CORE{hit[r]}} & ~q[N_CORE-1:0] &  wdata_i[N_CORE-1:0];
      assign core_fall_o = {N_CORE{hit[r]}} &  q[N_CORE-1:0] & ~wdata_i[N_CORE-1:0];
    end else if (r == IDX_DMA) begin : g_dma
      assign dma_chg_o = hit[r] && (q[0] != wdata_i[0]);
    end else if (r >= IDX_PERIPH0) begin : g_per
      assign periph_chg_o[r-IDX_PERIPH0] = hit[r] && (q[0] != wdata_i[0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_REGS; r++) rdata_o |= rd_part[r];
  end
endmodule

// File: rtl/rst_edge_pulse.sv
module rst_edge_pulse #(
  parameter int unsigned          N_PERIPH   = 6,
  parameter int unsigned          N_DMA      = 8,
  parameter logic [N_PERIPH-1:0]  PERIPH_TGT = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dma_chg_i,
  input  logic [N_PERIPH-1:0] periph_chg_i,
  output logic [N_PERIPH-1:0] periph_rst_o,
  output logic [N_DMA-1:0]    dma_rst_o
);
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
    if (PERIPH_TGT[i]) begin : g_tgt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) periph_rst_o[i] <= 1'b0;
        else         periph_rst_o[i] <= periph_chg_i[i];
      end
    end else begin : g_none
      logic unused_chg;
      assign unused_chg      = periph_chg_i[i];
      assign periph_rst_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_rst_o <= '0;
    else         dma_rst_o <= {N_DMA{dma_chg_i}};
  end
endmodule

// File: rtl/rst_edge_core_req.sv
module rst_edge_core_req
  import rst_edge_pkg::*;
#(
  parameter int unsigned N_CORE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CORE-1:0] rise_i,
  input  logic [N_CORE-1:0] fall_i,
  input  logic [N_CORE-1:0] ack_i,
  output logic [N_CORE-1:0] off_req_o,
  output logic [N_CORE-1:0] on_req_o
);
  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    core_req_e st_q, st_d;

    always_comb begin
      st_d = st_q;
      if (rise_i[c])      st_d = REQ_OFF;   // new edge wins over ack
      else if (fall_i[c]) st_d = REQ_ON;
      else if (ack_i[c])  st_d = REQ_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= REQ_IDLE;
      else         st_q <= st_d;
    end

    assign off_req_o[c] = (st_q == REQ_OFF);
    assign on_req_o[c]  = (st_q == REQ_ON);
  end
endmodule

// File: rtl/rst_edge_bank.sv
module rst_edge_bank
  import rst_edge_pkg::*;
#(
  parameter int unsigned         N_PERIPH   = 6,
  parameter int unsigned         N_DMA      = 8,
  parameter int unsigned         N_CORE     = 2,
  parameter int unsigned         ADDR_W     = 5,
  parameter logic [N_PERIPH-1:0] PERIPH_TGT = 6'b011111
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [N_PERIPH-1:0] periph_rst_o,
  output logic [N_DMA-1:0]    dma_rst_o,
  output logic [N_CORE-1:0]   core_off_req_o,
  output logic [N_CORE-1:0]   core_on_req_o,
  input  logic [N_CORE-1:0]   core_ack_i
);
  localparam int unsigned N_REGS = IDX_PERIPH0 + N_PERIPH;

  initial begin
    if (N_CORE < 1 || N_CORE > 3) $error("N_CORE must be 1..3");
    if (N_REGS > (1 << ADDR_W))  $error("ADDR_W too small for register count");
  end

  logic [N_CORE-1:0]   core_rise, core_fall;
  logic                dma_chg;
  logic [N_PERIPH-1:0] periph_chg;

  rst_edge_regs #(
    .N_PERIPH (N_PERIPH),
    .N_CORE   (N_CORE),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .core_rise_o  (core_rise),
    .core_fall_o  (core_fall),
    .dma_chg_o    (dma_chg),
    .periph_chg_o (periph_chg)
  );

  rst_edge_pulse #(
    .N_PERIPH   (N_PERIPH),
    .N_DMA      (N_DMA),
    .PERIPH_TGT (PERIPH_TGT)
  ) u_pulse (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dma_chg_i    (dma_chg),
    .periph_chg_i (periph_chg),
    .periph_rst_o (periph_rst_o),
    .dma_rst_o    (dma_rst_o)
  );

  rst_edge_core_req #(
    .N_CORE (N_CORE)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (core_rise),
    .fall_i    (core_fall),
    .ack_i     (core_ack_i),
    .off_req_o (core_off_req_o),
    .on_req_o  (core_on_req_o)
  );
endmodule

// File: rtl/rst_edge_bank_chk.sv
module rst_edge_bank_chk
  import rst_edge_pkg::*;
#(
  parameter int unsigned N_PERIPH = 6,
  parameter int unsigned N_DMA    = 8,
  parameter int unsigned N_CORE   = 2,
  parameter int unsigned ADDR_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         rdata_o,
  input logic [N_PERIPH-1:0] periph_rst_o,
  input logic [N_DMA-1:0]    dma_rst_o,
  input logic [N_CORE-1:0]   core_off_req_o,
  input logic [N_CORE-1:0]   core_on_req_o,
  input logic [N_CORE-1:0]   core_ack_i
);
  localparam int unsigned N_REGS = IDX_PERIPH0 + N_PERIPH;

  p_rsvd_read_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~reg_mask(int'(addr_i), N_REGS)) == '0);

  p_pulse_needs_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|periph_rst_o) |-> $past(we_i));

  p_dma_all_or_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_rst_o == '0) || (dma_rst_o == '1));

  for (genvar c = 0; c < N_CORE; c++) begin : g_c
    p_req_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(core_off_req_o[c] && core_on_req_o[c]));

    p_off_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_off_req_o[c] && !core_ack_i[c] && !we_i) |=> core_off_req_o[c]);

    p_on_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_on_req_o[c] && !core_ack_i[c] && !we_i) |=> core_on_req_o[c]);
  end
endmodule

bind rst_edge_bank rst_edge_bank_chk #(
  .N_PERIPH (N_PERIPH),
  .N_DMA    (N_DMA),
  .N_CORE   (N_CORE),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .rdata_o        (rdata_o),
  .periph_rst_o   (periph_rst_o),
  .dma_rst_o      (dma_rst_o),
  .core_off_req_o (core_off_req_o),
  .core_on_req_o  (core_on_req_o),
  .core_ack_i     (core_ack_i)
);

// File: tb/rst_edge_bank_tb.sv
`timescale 1ns/1ps
module rst_edge_bank_tb;
  localparam int N_PERIPH = 6;
  localparam int N_DMA    = 8;
  localparam int N_CORE   = 2;
  localparam int ADDR_W   = 5;
  localparam logic [N_PERIPH-1:0] TGT = 6'b011111;
  localparam int N_REGS   = 6 + N_PERIPH;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                we_i = 1'b0;
  logic [ADDR_W-1:0]   addr_i = '0;
  logic [31:0]         wdata_i = '0;
  logic [31:0]         rdata_o;
  logic [N_PERIPH-1:0] periph_rst_o;
  logic [N_DMA-1:0]    dma_rst_o;
  logic [N_CORE-1:0]   core_off_req_o, core_on_req_o;
  logic [N_CORE-1:0]   core_ack_i = '0;

  always #2.5 clk = ~clk;

  rst_edge_bank #(
    .N_PERIPH(N_PERIPH), .N_DMA(N_DMA), .N_CORE(N_CORE),
    .ADDR_W(ADDR_W), .PERIPH_TGT(TGT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .periph_rst_o(periph_rst_o),
    .dma_rst_o(dma_rst_o), .core_off_req_o(core_off_req_o),
    .core_on_req_o(core_on_req_o), .core_ack_i(core_ack_i)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [31:0]         exp_q [N_REGS];
  logic [N_PERIPH-1:0] exp_pp;
  logic [N_DMA-1:0]    exp_dp;
  logic [N_CORE-1:0]   exp_off, exp_on;

  function automatic logic [31:0] mask_of(int idx);
    if (idx < 0 || idx >= N_REGS) return 32'h0;
    case (idx)
      0: return 32'h17;
      1: return 32'h1;
      2: return 32'hF;
      3: return 32'h3;
      4: return 32'h33;
      5: return 32'h07;
      default: return 32'h1;
    endcase
  endfunction

  function automatic logic [31:0] init_of(int idx);
    case (idx)
      0: return 32'h17;
      2: return 32'hF;
      3: return 32'h3;
      4: return 32'h33;
      default: return 32'h1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(int idx);
    if (idx >= N_REGS) return 32'h0;
    return exp_q[idx];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle, check read, advance model, check outputs.
  task automatic cyc(logic we, int a, logic [31:0] d, logic [N_CORE-1:0] ack, string rtag);
    logic [31:0] old;
    we_i = we; addr_i = ADDR_W'(a); wdata_i = d; core_ack_i = ack;
    #1;
    chk(rtag, rdata_o, model_read(a));
    old = model_read(a);
    exp_pp = '0;
    exp_dp = '0;
    for (int c = 0; c < N_CORE; c++) begin
      if (we && a == 0 && !old[c] && d[c])      begin exp_off[c] = 1'b1; exp_on[c] = 1'b0; end
      else if (we && a == 0 && old[c] && !d[c]) begin exp_on[c] = 1'b1; exp_off[c] = 1'b0; end
      else if (ack[c])                          begin exp_on[c] = 1'b0; exp_off[c] = 1'b0; end
    end
    if (we && a == 1 && (old[0] != d[0])) exp_dp = '1;
    if (we && a >= 6 && a < N_REGS && (old[0] != d[0]))
      exp_pp[a-6] = TGT[a-6];
    if (we && a < N_REGS) exp_q[a] = d & mask_of(a);
    @(negedge clk);
    chk("R4/R8 periph pulse", 32'(periph_rst_o), 32'(exp_pp));
    chk("R5 dma pulse", 32'(dma_rst_o), 32'(exp_dp));
    chk("R6/R7 off req", 32'(core_off_req_o), 32'(exp_off));
    chk("R6/R7 on req", 32'(core_on_req_o), 32'(exp_on));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd24681));
    for (int i = 0; i < N_REGS; i++) exp_q[i] = init_of(i);
    exp_off = '0; exp_on = '0; exp_pp = '0; exp_dp = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset values and quiet outputs
    for (int i = 0; i < N_REGS; i++) cyc(1'b0, i, 32'h0, '0, "R1 reset value");

    // R4: same value gives no pulse, each direction pulses
    cyc(1'b1, 6, 32'h1, '0, "R3");
    cyc(1'b1, 6, 32'h0, '0, "R3");
    cyc(1'b1, 6, 32'h1, '0, "R3");
    cyc(1'b1, 7, 32'hFFFF_FFFE, '0, "R3");
    // R8: untargeted peripheral stores the change, no pulse
    cyc(1'b1, 11, 32'h0, '0, "R3");
    cyc(1'b0, 11, 32'h0, '0, "R8 stored value");
    // R5: dma fan-out
    cyc(1'b1, 1, 32'h0, '0, "R3");
    cyc(1'b1, 1, 32'h0, '0, "R3");
    cyc(1'b1, 1, 32'h1, '0, "R3");
    // R2: reserved bits and unmapped index
    cyc(1'b1, 4, 32'hFFFF_FFFF, '0, "R3");
    cyc(1'b0, 4, 32'h0, '0, "R2 debug mask");
    cyc(1'b1, 5, 32'hFFFF_FFFF, '0, "R3");
    cyc(1'b0, 5, 32'h0, '0, "R2 mode mask");
    cyc(1'b1, 31, 32'hFFFF_FFFF, '0, "R2 unmapped");
    cyc(1'b0, 31, 32'h0, '0, "R2 unmapped read");
    // R9: storage-only registers and non-core bits
    cyc(1'b1, 2, 32'h0, '0, "R3");
    cyc(1'b1, 3, 32'h0, '0, "R3");
    cyc(1'b1, 0, 32'h03, '0, "R3");
    // R6: fall -> on request, held without ack
    cyc(1'b1, 0, 32'h00, '0, "R3");
    cyc(1'b0, 0, 32'h0, '0, "R6 hold");
    cyc(1'b0, 0, 32'h0, '0, "R6 hold");
    cyc(1'b0, 0, 32'h0, 2'b01, "R6 ack core0");
    // R7: rise replaces pending on-request of core1; edge beats ack
    cyc(1'b1, 0, 32'h02, 2'b10, "R7 replace");
    cyc(1'b1, 0, 32'h03, 2'b01, "R7 edge beats ack");
    cyc(1'b0, 0, 32'h0, 2'b11, "R7 ack clears");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int a;
      logic [31:0] d;
      logic w;
      a = ($urandom_range(0, 19) == 0) ? 31 : int'($urandom_range(0, N_REGS + 1));
      d = $urandom();
      w = ($urandom_range(0, 9) < 7);
      cyc(w, a, d, N_CORE'($urandom_range(0, 3) == 0 ? $urandom() : 0), "R3 readback");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule